// File: doc/BRIEF.md
# Real-Mode Segmented Address Generator

This block forms physical memory addresses the way a real-mode processor does. It holds six 16-bit segment registers, which are loaded through a simple write port. For every access, the caller supplies a 16-bit offset and an access kind. The block then picks a segment register and returns the segment value times sixteen plus the offset, as a 21-bit address.

The access kind decides which register is used. Instruction fetches are tied to the code register and stack accesses are tied to the stack register. Only data accesses follow the caller's segment choice. A gate register controls bit 20 of the result. When the gate is closed, the sum wraps at one megabyte. When the gate is open, the carry out of the 20-bit sum appears as bit 20.

Address generation is purely combinational from the current register contents. Register and gate writes take effect at the next rising clock.

Top module: `rmode_addr_gen`

## Requirements
- R1: Write index 0..5 selects code, data, extra, F, G and stack in that order. A write takes effect at the next rising clock. Write indices 6 and 7 change no register, and with the write enable low no register changes.
- R2: An active-low reset clears all six segment registers to zero and closes the gate.
- R3: Bits 19:0 of the address equal the low 20 bits of (segment << 4) + offset. For example, 0x1000:0xABCD gives 0x1ABCD and 0x0001:0x0010 gives 0x00020.
- R4: With the gate closed, bit 20 of the address is 0, so 0xFFFF:0x0010 gives 0x000000.
- R5: With the gate open, bit 20 is the carry out of the 20-bit sum, so 0xFFFF:0x0010 gives 0x100000.
- R6: Access kind 1 (fetch) always uses the code register, whatever the segment-select input holds.
- R7: Access kind 2 (stack) always uses the stack register, whatever the segment-select input holds.
- R8: Access kind 0 (data) uses the register named by the 3-bit segment select, coded the same way as the write index.
- R9: A data access with select 6 or 7, or any access of kind 3, raises the error output and uses a segment base of zero. No other access raises the error output.
- R10: An access made in the same cycle as a write to its register sees the old value. The next cycle sees the new value.
- R11: The gate write loads the gate value at the next rising clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| seg_wr_en | input | 1 | Segment register write enable |
| seg_wr_idx | input | 3 | Segment register write index |
| seg_wr_val | input | 16 | Value to write |
| gate_we | input | 1 | Gate register write enable |
| gate_val | input | 1 | Gate value to load (1 = open) |
| acc_kind | input | 2 | Access kind: 0 data, 1 fetch, 2 stack, 3 reserved |
| acc_sel | input | 3 | Segment select for data accesses |
| acc_off | input | 16 | Access offset |
| phys_addr | output | 21 | Physical address |
| sel_err | output | 1 | Invalid segment choice or access kind |

## Verification
A register write and an address computation that reads the same register can happen in the same cycle. This also applies to a gate write and an access whose sum carries into bit 20. The bench drives both together at a falling edge. It then samples the address once before the next rising edge, where the old value is expected, and once after it, where the new value is expected. Forced segment selection is tested by loading a distinctive value into the register named by the select input and confirming that fetch and stack accesses ignore it.

// File: rtl/seg_agen_pkg.sv
package seg_agen_pkg;
    localparam int SEG_W   = 16;
    localparam int OFF_W   = 16;
    localparam int SHIFT   = 4;
    localparam int NUM_SEG = 6;
    localparam int IDX_W   = 3;
    localparam int ADDR_W  = SEG_W + SHIFT + 1;

    localparam logic [IDX_W-1:0] IDX_CODE  = 3'd0;
    localparam logic [IDX_W-1:0] IDX_STACK = 3'd5;

    typedef enum logic [1:0] {
        ACC_DATA  = 2'd0,
        ACC_FETCH = 2'd1,
        ACC_STACK = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_kind_e;

    typedef logic [NUM_SEG-1:0][SEG_W-1:0] seg_bank_t;

    typedef struct packed {
        seg_bank_t seg;
        logic      gate;
    } seg_state_t;
endpackage

// File: rtl/seg_state.sv
module seg_state
    import seg_agen_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [SEG_W-1:0] wr_val,
    input  logic             gate_we,
    input  logic             gate_val,
    output seg_bank_t        bank,
    output logic             gate
);
    seg_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        for (int i = 0; i < NUM_SEG; i++) begin
            if (wr_en && (wr_idx == IDX_W'(i))) begin
                state_d.seg[i] = wr_val;
            end
        end
        if (gate_we) begin
            state_d.gate = gate_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign bank = state_q.seg;
    assign gate = state_q.gate;
endmodule

// File: rtl/seg_pick.sv
module seg_pick
    import seg_agen_pkg::*;
(
    input  seg_bank_t        bank,
    input  logic [1:0]       kind,
    input  logic [IDX_W-1:0] sel,
    output logic [SEG_W-1:0] base,
    output logic             err
);
    always_comb begin
        base = '0;
        err  = 1'b0;
        case (acc_kind_e'(kind))
            ACC_FETCH: base = bank[IDX_CODE];
            ACC_STACK: base = bank[IDX_STACK];
            ACC_DATA: begin
                if (sel < IDX_W'(NUM_SEG)) begin
                    base = bank[sel];
                end else begin
                    err = 1'b1;
                end
            end
            default: err = 1'b1;
        endcase
    end
endmodule

// File: rtl/addr_sum.sv
module addr_sum
    import seg_agen_pkg::*;
(
    input  logic [SEG_W-1:0]  base,
    input  logic [OFF_W-1:0]  off,
    input  logic              gate,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] raw;

    always_comb begin
        raw  = {1'b0, base, {SHIFT{1'b0}}} + ADDR_W'(off);
        addr = {raw[ADDR_W-1] & gate, raw[ADDR_W-2:0]};
    end
endmodule

// File: rtl/rmode_addr_gen.sv
module rmode_addr_gen
    import seg_agen_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        seg_wr_en,
    input  logic [2:0]  seg_wr_idx,
    input  logic [15:0] seg_wr_val,
    input  logic        gate_we,
    input  logic        gate_val,
    input  logic [1:0]  acc_kind,
    input  logic [2:0]  acc_sel,
    input  logic [15:0] acc_off,
    output logic [20:0] phys_addr,
    output logic        sel_err
);
    seg_bank_t        bank;
    logic             gate_q;
    logic [SEG_W-1:0] base_used;

    seg_state u_state (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (seg_wr_en),
        .wr_idx  (seg_wr_idx),
        .wr_val  (seg_wr_val),
        .gate_we (gate_we),
        .gate_val(gate_val),
        .bank    (bank),
        .gate    (gate_q)
    );

    seg_pick u_pick (
        .bank(bank),
        .kind(acc_kind),
        .sel (acc_sel),
        .base(base_used),
        .err (sel_err)
    );

    addr_sum u_sum (
        .base(base_used),
        .off (acc_off),
        .gate(gate_q),
        .addr(phys_addr)
    );
endmodule

// File: rtl/rmode_addr_gen_chk.sv
module rmode_addr_gen_chk
    import seg_agen_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             seg_wr_en,
    input logic [1:0]       acc_kind,
    input logic [2:0]       acc_sel,
    input logic [20:0]      phys_addr,
    input logic             sel_err,
    input logic             gate_q,
    input seg_bank_t        bank,
    input logic [SEG_W-1:0] base_used
);
    AST_FETCH_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_kind == 2'd1) |-> (base_used == bank[0]));                 // R6
    AST_STACK_SS: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_kind == 2'd2) |-> (base_used == bank[5]));                 // R7
    AST_GATE_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_q |-> !phys_addr[20]);                                    // R4
    AST_BAD_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        ((acc_kind == 2'd0) && (acc_sel > 3'd5)) |-> (sel_err && base_used == '0)); // R9
    AST_NO_FALSE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        ((acc_kind == 2'd1) || (acc_kind == 2'd2) ||
         ((acc_kind == 2'd0) && (acc_sel < 3'd6))) |-> !sel_err);       // R9
    AST_SEG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !seg_wr_en |=> $stable(bank));                                  // R1
endmodule

bind rmode_addr_gen rmode_addr_gen_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .seg_wr_en(seg_wr_en),
    .acc_kind (acc_kind),
    .acc_sel  (acc_sel),
    .phys_addr(phys_addr),
    .sel_err  (sel_err),
    .gate_q   (gate_q),
    .bank     (bank),
    .base_used(base_used)
);

// File: tb/rmode_addr_gen_tb.sv
module rmode_addr_gen_tb;
    localparam int CLK_P = 10;
    localparam int NVEC  = 11;

    typedef struct packed {
        logic [2:0]  w;
        logic [15:0] v;
        logic        g;
        logic [1:0]  k;
        logic [2:0]  s;
        logic [15:0] o;
        logic [20:0] ea;
        logic        ee;
    } vec_t;

    // vectors: load one register, set gate, then access
    localparam vec_t VECS [NVEC] = '{
        '{3'd1, 16'h1000, 1'b0, 2'd0, 3'd1, 16'hABCD, 21'h01ABCD, 1'b0}, // R3 R8
        '{3'd1, 16'h0001, 1'b0, 2'd0, 3'd1, 16'h0010, 21'h000020, 1'b0}, // R3
        '{3'd2, 16'hFFFF, 1'b0, 2'd0, 3'd2, 16'h0010, 21'h000000, 1'b0}, // R4
        '{3'd2, 16'hFFFF, 1'b1, 2'd0, 3'd2, 16'h0010, 21'h100000, 1'b0}, // R5
        '{3'd0, 16'hF000, 1'b1, 2'd1, 3'd2, 16'hFFFF, 21'h0FFFFF, 1'b0}, // R6
        '{3'd5, 16'h1234, 1'b0, 2'd2, 3'd0, 16'h0005, 21'h012345, 1'b0}, // R7
        '{3'd3, 16'h0ABC, 1'b1, 2'd0, 3'd3, 16'h0004, 21'h00ABC4, 1'b0}, // R8
        '{3'd4, 16'hFFFF, 1'b1, 2'd0, 3'd4, 16'hFFFF, 21'h10FFEF, 1'b0}, // R5
        '{3'd4, 16'hFFFF, 1'b0, 2'd0, 3'd4, 16'hFFFF, 21'h00FFEF, 1'b0}, // R4
        '{3'd0, 16'h0000, 1'b0, 2'd0, 3'd6, 16'h1234, 21'h001234, 1'b1}, // R9
        '{3'd0, 16'h0000, 1'b0, 2'd3, 3'd0, 16'h0042, 21'h000042, 1'b1}  // R9
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        seg_wr_en = 1'b0;
    logic [2:0]  seg_wr_idx = '0;
    logic [15:0] seg_wr_val = '0;
    logic        gate_we = 1'b0;
    logic        gate_val = 1'b0;
    logic [1:0]  acc_kind = '0;
    logic [2:0]  acc_sel = '0;
    logic [15:0] acc_off = '0;
    logic [20:0] phys_addr;
    logic        sel_err;

    int checks = 0;
    int errors = 0;

    always #(CLK_P/2) clk = ~clk;

    rmode_addr_gen u_dut (
        .clk(clk), .rst_n(rst_n),
        .seg_wr_en(seg_wr_en), .seg_wr_idx(seg_wr_idx), .seg_wr_val(seg_wr_val),
        .gate_we(gate_we), .gate_val(gate_val),
        .acc_kind(acc_kind), .acc_sel(acc_sel), .acc_off(acc_off),
        .phys_addr(phys_addr), .sel_err(sel_err)
    );

    task automatic chk(input string tag, input logic [20:0] ea, input logic ee);
        checks++;
        if (phys_addr !== ea || sel_err !== ee) begin
            errors++;
            $display("FAIL %s: addr %h err %b, expected addr %h err %b",
                     tag, phys_addr, sel_err, ea, ee);
        end
    endtask

    task automatic access(input logic [1:0] k, input logic [2:0] s, input logic [15:0] o);
        acc_kind = k; acc_sel = s; acc_off = o;
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
    endtask

    initial begin
        #(CLK_P * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        do_reset();

        // R2: all registers zero after reset
        for (int i = 0; i < 6; i++) begin
            access(2'd0, 3'(i), 16'h1234);
            chk("R2 segment zero after reset", 21'h001234, 1'b0);
        end
        // R2: gate closed after reset
        @(negedge clk); seg_wr_en = 1; seg_wr_idx = 3'd2; seg_wr_val = 16'hFFFF;
        @(negedge clk); seg_wr_en = 0;
        access(2'd0, 3'd2, 16'h0010);
        chk("R2 gate closed after reset", 21'h000000, 1'b0);

        // R1: writes to index 6 and 7 ignored
        do_reset();
        @(negedge clk); seg_wr_en = 1; seg_wr_idx = 3'd6; seg_wr_val = 16'h5555;
        @(negedge clk); seg_wr_idx = 3'd7;
        @(negedge clk); seg_wr_en = 0;
        for (int i = 0; i < 6; i++) begin
            access(2'd0, 3'(i), 16'h0007);
            chk("R1 index 6/7 write ignored", 21'h000007, 1'b0);
        end
        // R1: enable low, value present, no change
        @(negedge clk); seg_wr_idx = 3'd3; seg_wr_val = 16'h7777;
        @(negedge clk);
        access(2'd0, 3'd3, 16'h0000);
        chk("R1 no write with enable low", 21'h000000, 1'b0);

        // vector table
        for (int n = 0; n < NVEC; n++) begin
            @(negedge clk);
            seg_wr_en = 1; seg_wr_idx = VECS[n].w; seg_wr_val = VECS[n].v;
            gate_we = 1; gate_val = VECS[n].g;
            @(negedge clk);
            seg_wr_en = 0; gate_we = 0;
            access(VECS[n].k, VECS[n].s, VECS[n].o);
            chk($sformatf("R3 R4 R5 R6 R7 R8 R9 vector %0d", n), VECS[n].ea, VECS[n].ee);
        end

        // R10: same-cycle write and read of the data register
        do_reset();
        @(negedge clk); seg_wr_en = 1; seg_wr_idx = 3'd1; seg_wr_val = 16'h0100;
        @(negedge clk); seg_wr_val = 16'h0200;
        access(2'd0, 3'd1, 16'h0000);
        chk("R10 old value before edge", 21'h001000, 1'b0);
        @(negedge clk); seg_wr_en = 0;
        #1;
        chk("R10 new value after edge", 21'h002000, 1'b0);

        // R11: gate write with a carrying access in the same cycle
        @(negedge clk); seg_wr_en = 1; seg_wr_idx = 3'd2; seg_wr_val = 16'hFFFF;
        @(negedge clk); seg_wr_en = 0; gate_we = 1; gate_val = 1;
        access(2'd0, 3'd2, 16'h0010);
        chk("R11 gate still closed before edge", 21'h000000, 1'b0);
        @(negedge clk); gate_we = 0;
        #1;
        chk("R11 gate open after edge", 21'h100000, 1'b0);
        // R11: gate held when its write enable is low
        gate_val = 0;
        @(negedge clk); #1;
        chk("R11 gate held without write", 21'h100000, 1'b0);

        // R6/R7: forced selection ignores select pointing at a loaded register
        access(2'd1, 3'd2, 16'h0010);
        chk("R6 fetch ignores select", 21'h000010, 1'b0);
        access(2'd2, 3'd2, 16'h0010);
        chk("R7 stack ignores select", 21'h000010, 1'b0);
        access(2'd0, 3'd7, 16'h0010);
        chk("R9 select 7 error", 21'h000010, 1'b1);

        // R2: reset after loading clears registers and gate
        do_reset();
        access(2'd0, 3'd2, 16'h0010);
        chk("R2 reset clears loaded register", 21'h000010, 1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule